// File: doc/BRIEF.md
# Sub-Vector Transposing Index Generator

This block issues the element offsets for a register-to-register move over a vector of `VL` groups, each group holding `SUBVL` sub-elements (one to four). Two offset walkers, one for the source side and one for the destination side, advance together by one step for every pair the consumer accepts. Each walker walks its elements in one of two orders, and the choice is made separately for each side:

- **group-major**: the group loop is outer and the sub-element loop is inner, so offsets run 0, 1, 2, ... in sequence.
- **lane-major**: the sub-element loop is outer and the group loop is inner, so the offset `i*SUBVL + j` strides by `SUBVL` and restarts at the next lane.

Running one side lane-major and the other group-major transposes the sub-vector elements. This gathers like sub-elements together (pack) or scatters them back into their groups (unpack).

A `start` pulse loads the configuration and restarts both walkers. The block then presents one (source, destination) offset pair at a time, together with a flag that marks the final pair. The pair is held until `advance` accepts it. Both walkers use counters with wrap logic and incremental offset updates; no multiplier is involved.

Top module: `subvec_reorder_idx`

## Requirements
- R1: After reset `out_valid` is 0.
- R2: The cycle after `start` with a nonzero `cfg_vl`, `out_valid` is 1 and the pair is (0, 0). `start` takes priority over `advance` in that cycle.
- R3: A side whose swap enable is 0 walks group-major. Its offsets are 0, 1, ..., VL*SUBVL-1 in order.
- R4: With `cfg_pack`=1 the source side walks lane-major. For step k it issues offset (k mod VL)*SUBVL + (k div VL); for example VL=2, SUBVL=3 gives 0,3,1,4,2,5.
- R5: With `cfg_unpack`=1 the destination side walks lane-major, using the R4 formula.
- R6: Both enables may be set at once. Both sides then walk lane-major, and every pair has equal offsets.
- R7: Exactly VL*SUBVL pairs are issued. `out_last` is 1 on the final pair only, and `out_valid` drops the cycle after that pair is accepted.
- R8: While `out_valid`=1 and `advance`=0 (and no `start`), the pair, `out_last` and `out_valid` hold their values.
- R9: `start` with `cfg_vl`=0 issues no pair; `out_valid` stays 0.
- R10: When SUBVL=1, both orders give the same sequence 0..VL-1 on both sides.
- R11: `start` while a sequence is in progress abandons it. The next cycle shows (0, 0) under the new configuration.
- R12: `cfg_subvl_m1` encodes SUBVL-1 (0 means 1, 3 means 4) and is sampled only at `start`, together with `cfg_vl` and both enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load configuration and restart both walkers |
| cfg_vl | input | VL_W | Group count VL |
| cfg_subvl_m1 | input | 2 | SUBVL minus one |
| cfg_pack | input | 1 | Source side walks lane-major |
| cfg_unpack | input | 1 | Destination side walks lane-major |
| advance | input | 1 | Consumer accepts the current pair |
| out_valid | output | 1 | A pair is presented |
| out_src | output | VL_W+2 | Source element offset |
| out_dst | output | VL_W+2 | Destination element offset |
| out_last | output | 1 | Current pair is the final one |

## Verification
Every result is one register stage from its cause:
- The first pair appears in the cycle after `start`.
- Each following pair appears in the cycle after the edge that accepted the previous one.
- `out_valid` falls in the cycle after the final pair is accepted.

The bench drives inputs on falling edges and checks outputs on the next falling edge. Each check therefore sees the state produced by exactly one rising edge. Expected offsets come from the closed-form step formula in R4, evaluated for every step k.

// File: rtl/subvec_pkg.sv
package subvec_pkg;

   typedef enum logic {
      ORD_GROUP_MAJOR = 1'b0,
      ORD_LANE_MAJOR  = 1'b1
   } walk_order_e;

   localparam int SUBVL_FIELD_W = 2;

   function automatic walk_order_e order_of(input logic swap_en);
      return swap_en ? ORD_LANE_MAJOR : ORD_GROUP_MAJOR;
   endfunction

endpackage

// File: rtl/subvec_walker.sv
module subvec_walker
   import subvec_pkg::*;
#(
   parameter int VL_W  = 6,
   parameter int IDX_W = VL_W + 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     step,
   input  walk_order_e              ord_in,
   input  logic [VL_W-1:0]          vl_in,
   input  logic [SUBVL_FIELD_W-1:0] sub_m1_in,
   output logic [IDX_W-1:0]         idx,
   output logic                     at_end
);

   localparam int PAD_W = IDX_W - VL_W;

   walk_order_e              ord_q;
   logic [VL_W-1:0]          vl_q;
   logic [SUBVL_FIELD_W-1:0] sub_m1_q;
   logic [VL_W-1:0]          inner_q;
   logic [VL_W-1:0]          outer_q;
   logic [IDX_W-1:0]         idx_q;

   logic [VL_W-1:0]          inner_lim;
   logic [VL_W-1:0]          outer_lim;
   logic [IDX_W-1:0]         stride;
   logic                     inner_wrap;
   logic [IDX_W-1:0]         next_lane_base;

   always_comb begin
      if (ord_q == ORD_LANE_MAJOR) begin
         inner_lim = vl_q - 1'b1;
         outer_lim = VL_W'(sub_m1_q);
         stride    = IDX_W'(sub_m1_q) + 1'b1;
      end else begin
         inner_lim = VL_W'(sub_m1_q);
         outer_lim = vl_q - 1'b1;
         stride    = IDX_W'(1);
      end
      inner_wrap     = (inner_q == inner_lim);
      next_lane_base = {{PAD_W{1'b0}}, outer_q} + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ord_q    <= ORD_GROUP_MAJOR;
         vl_q     <= '0;
         sub_m1_q <= '0;
         inner_q  <= '0;
         outer_q  <= '0;
         idx_q    <= '0;
      end else if (load) begin
         ord_q    <= ord_in;
         vl_q     <= vl_in;
         sub_m1_q <= sub_m1_in;
         inner_q  <= '0;
         outer_q  <= '0;
         idx_q    <= '0;
      end else if (step) begin
         if (inner_wrap) begin
            inner_q <= '0;
            outer_q <= outer_q + 1'b1;
            idx_q   <= (ord_q == ORD_LANE_MAJOR) ? next_lane_base : idx_q + 1'b1;
         end else begin
            inner_q <= inner_q + 1'b1;
            idx_q   <= idx_q + stride;
         end
      end
   end

   assign idx    = idx_q;
   assign at_end = inner_wrap && (outer_q == outer_lim);

endmodule

// File: rtl/subvec_issue_ctl.sv
module subvec_issue_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic vl_nonzero,
   input  logic advance,
   input  logic final_pair,
   output logic load,
   output logic step,
   output logic busy
);

   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= vl_nonzero;
      end else if (busy_q && advance && final_pair) begin
         busy_q <= 1'b0;
      end
   end

   assign load = start;
   assign step = busy_q && advance && !start;
   assign busy = busy_q;

endmodule

// File: rtl/subvec_reorder_idx.sv
module subvec_reorder_idx
   import subvec_pkg::*;
#(
   parameter int VL_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [VL_W-1:0]          cfg_vl,
   input  logic [SUBVL_FIELD_W-1:0] cfg_subvl_m1,
   input  logic                     cfg_pack,
   input  logic                     cfg_unpack,
   input  logic                     advance,
   output logic                     out_valid,
   output logic [VL_W+1:0]          out_src,
   output logic [VL_W+1:0]          out_dst,
   output logic                     out_last
);

   localparam int IDX_W   = VL_W + SUBVL_FIELD_W;
   localparam int N_SIDES = 2;

   generate
      if (VL_W < 2) begin : g_bad_vl_w
         $error("VL_W must be at least 2");
      end
   endgenerate

   logic             load;
   logic             step;
   logic             busy;
   logic [IDX_W-1:0] side_idx [N_SIDES];
   logic             side_end [N_SIDES];
   logic [1:0]       side_swap;

   assign side_swap = {cfg_unpack, cfg_pack};

   subvec_issue_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .vl_nonzero (cfg_vl != '0),
      .advance    (advance),
      .final_pair (side_end[0]),
      .load       (load),
      .step       (step),
      .busy       (busy)
   );

   for (genvar s = 0; s < N_SIDES; s++) begin : g_side
      subvec_walker #(
         .VL_W  (VL_W),
         .IDX_W (IDX_W)
      ) u_walk (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .step      (step),
         .ord_in    (order_of(side_swap[s])),
         .vl_in     (cfg_vl),
         .sub_m1_in (cfg_subvl_m1),
         .idx       (side_idx[s]),
         .at_end    (side_end[s])
      );
   end

   assign out_valid = busy;
   assign out_src   = side_idx[0];
   assign out_dst   = side_idx[1];
   assign out_last  = busy && side_end[0];

endmodule

// File: rtl/subvec_reorder_idx_chk.sv
module subvec_reorder_idx_chk #(
   parameter int VL_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [VL_W-1:0] cfg_vl,
   input logic [1:0]      cfg_subvl_m1,
   input logic            cfg_pack,
   input logic            cfg_unpack,
   input logic            advance,
   input logic            out_valid,
   input logic [VL_W+1:0] out_src,
   input logic [VL_W+1:0] out_dst,
   input logic            out_last
);

   logic [VL_W-1:0] cap_vl;
   logic [1:0]      cap_sub_m1;
   logic            cap_pack;
   logic            cap_unpack;
   logic [VL_W+2:0] cap_total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_vl     <= '0;
         cap_sub_m1 <= '0;
         cap_pack   <= 1'b0;
         cap_unpack <= 1'b0;
      end else if (start) begin
         cap_vl     <= cfg_vl;
         cap_sub_m1 <= cfg_subvl_m1;
         cap_pack   <= cfg_pack;
         cap_unpack <= cfg_unpack;
      end
   end

   assign cap_total = (VL_W+3)'(cap_vl) * ((VL_W+3)'(cap_sub_m1) + 1'b1);

   assert_first_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start && (cfg_vl != '0) |=> out_valid && (out_src == '0) && (out_dst == '0));

   assert_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start && (cfg_vl == '0) |=> !out_valid);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !advance && !start |=>
         out_valid && $stable(out_src) && $stable(out_dst) && $stable(out_last));

   assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && advance && out_last && !start |=> !out_valid);

   assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((VL_W+3)'(out_src) < cap_total) && ((VL_W+3)'(out_dst) < cap_total));

   assert_seq_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && advance && !out_last && !start && !cap_pack |=>
         out_src == $past(out_src) + 1'b1);

   assert_same_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (cap_pack == cap_unpack) |-> out_src == out_dst);

   assert_single_sub_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (cap_sub_m1 == 2'd0) |-> out_src == out_dst);

endmodule

bind subvec_reorder_idx subvec_reorder_idx_chk #(.VL_W(VL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .cfg_vl       (cfg_vl),
   .cfg_subvl_m1 (cfg_subvl_m1),
   .cfg_pack     (cfg_pack),
   .cfg_unpack   (cfg_unpack),
   .advance      (advance),
   .out_valid    (out_valid),
   .out_src      (out_src),
   .out_dst      (out_dst),
   .out_last     (out_last)
);

// File: tb/subvec_reorder_idx_tb.sv
module subvec_reorder_idx_tb;

   localparam int VL_W = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [VL_W-1:0] cfg_vl = '0;
   logic [1:0]      cfg_subvl_m1 = '0;
   logic            cfg_pack = 1'b0;
   logic            cfg_unpack = 1'b0;
   logic            advance = 1'b0;
   logic            out_valid;
   logic [VL_W+1:0] out_src;
   logic [VL_W+1:0] out_dst;
   logic            out_last;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   subvec_reorder_idx #(.VL_W(VL_W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cfg_vl       (cfg_vl),
      .cfg_subvl_m1 (cfg_subvl_m1),
      .cfg_pack     (cfg_pack),
      .cfg_unpack   (cfg_unpack),
      .advance      (advance),
      .out_valid    (out_valid),
      .out_src      (out_src),
      .out_dst      (out_dst),
      .out_last     (out_last)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_off(input int k, input int vl, input int sub, input bit swap);
      if (!swap) return k;
      return (k % vl) * sub + (k / vl);
   endfunction

   task automatic issue_start(input int vl, input int sub, input bit pk, input bit up);
      @(negedge clk);
      cfg_vl       = VL_W'(vl);
      cfg_subvl_m1 = 2'(sub - 1);
      cfg_pack     = pk;
      cfg_unpack   = up;
      start        = 1'b1;
      @(negedge clk);
      start        = 1'b0;
      cfg_vl       = '0;
      cfg_subvl_m1 = 2'd3;
      cfg_pack     = ~pk;
      cfg_unpack   = ~up;
   endtask

   task automatic walk(input int vl, input int sub, input bit pk, input bit up,
                       input int from_k, input string tag);
      int n = vl * sub;
      for (int k = from_k; k < n; k++) begin
         check({tag, " valid"}, int'(out_valid), 1);
         check({tag, " src"}, int'(out_src), exp_off(k, vl, sub, pk));
         check({tag, " dst"}, int'(out_dst), exp_off(k, vl, sub, up));
         check({tag, " last R7"}, int'(out_last), (k == n - 1) ? 1 : 0);
         advance = 1'b1;
         @(negedge clk);
      end
      advance = 1'b0;
      check({tag, " drop R7"}, int'(out_valid), 0);
   endtask

   task automatic t_reset();
      check("R1 reset valid", int'(out_valid), 0);
   endtask

   task automatic t_run(input int vl, input int sub, input bit pk, input bit up,
                        input string tag);
      issue_start(vl, sub, pk, up);
      check({tag, " R2 first src"}, int'(out_src), 0);
      check({tag, " R2 first dst"}, int'(out_dst), 0);
      walk(vl, sub, pk, up, 0, tag);
   endtask

   task automatic t_stall();
      issue_start(3, 2, 1'b1, 1'b0);
      advance = 1'b1;
      @(negedge clk);
      @(negedge clk);
      advance = 1'b0;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check("R8 hold valid", int'(out_valid), 1);
         check("R8 hold src", int'(out_src), exp_off(2, 3, 2, 1'b1));
         check("R8 hold dst", int'(out_dst), 2);
      end
      walk(3, 2, 1'b1, 1'b0, 2, "R8 resume");
   endtask

   task automatic t_empty();
      issue_start(0, 4, 1'b0, 1'b0);
      for (int c = 0; c < 3; c++) begin
         check("R9 empty valid", int'(out_valid), 0);
         advance = 1'b1;
         @(negedge clk);
      end
      advance = 1'b0;
   endtask

   task automatic t_restart();
      issue_start(5, 4, 1'b0, 1'b1);
      advance = 1'b1;
      repeat (4) @(negedge clk);
      cfg_vl       = VL_W'(2);
      cfg_subvl_m1 = 2'd2;
      cfg_pack     = 1'b1;
      cfg_unpack   = 1'b0;
      start        = 1'b1;
      @(negedge clk);
      start        = 1'b0;
      advance      = 1'b0;
      check("R11 restart src", int'(out_src), 0);
      check("R11 restart dst", int'(out_dst), 0);
      walk(2, 3, 1'b1, 1'b0, 0, "R11 new cfg");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run(4, 1, 1'b0, 1'b0, "R3 R10 sub1 normal");
      t_run(4, 1, 1'b1, 1'b1, "R10 sub1 swapped");
      t_run(2, 3, 1'b1, 1'b0, "R4 pack");
      t_run(3, 4, 1'b0, 1'b1, "R5 unpack");
      t_run(3, 2, 1'b1, 1'b1, "R6 both");
      t_run(5, 3, 1'b0, 1'b0, "R3 normal");
      t_run(1, 1, 1'b1, 1'b0, "R7 single pair");
      t_run(63, 4, 1'b1, 1'b0, "R7 R12 max size");
      t_stall();
      t_empty();
      t_restart();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule